// File: doc/BRIEF.md
# SM4 Block Encryption Core with Concurrent Key Schedule

This block encrypts one 128-bit block with the SM4 cipher under a 128-bit key. A caller drives the key and the plaintext, pulses `start` while the core is idle, and collects the ciphertext on `dout` when `done` pulses. The core runs 32 rounds, one per clock.

Two round datapaths run side by side. One steps the key schedule. It first folds the key with a fixed 128-bit whitening constant, then builds a 32-bit round key each cycle from a constant that it generates on the fly. The other datapath steps the data state and takes that round key in the same cycle. No round key is ever stored, so the block holds two 128-bit state registers and a round counter and nothing more. When the last round finishes, the four data words are written out in reverse order. The result stays on `dout` until the next block completes.

Top module: `sm4_lockstep_enc`

## Requirements
- R1: While `rst` is high and after it falls, `busy` and `done` are 0 and `dout` is all zeros until the first block completes.
- R2: For every block, `dout` equals the SM4 encryption of `din` under `key_in`. Key and plaintext 0123456789abcdeffedcba9876543210 give 681edf34d206965e86b3e94f536e4246.
- R3: A block is accepted on a rising edge where `start` is 1 and `busy` is 0. `done` is then a one-cycle pulse raised on the 32nd rising edge after the accepting edge.
- R4: `busy` rises on the accepting edge and falls on the edge that raises `done`. The two are never 1 together.
- R5: A `start` that arrives while `busy` is 1 is ignored: the running block neither restarts nor changes, and no extra result is produced.
- R6: `dout` keeps its last result in every cycle where `done` is 0.
- R7: The key schedule begins from `key_in` XOR A3B1BAC6_56AA3350_677D9197_B27022DC. The first 32-bit word of every 128-bit port is bits 127:96.
- R8: Round constant i (0..31) has byte j, with j=0 as the most significant byte, equal to ((4i+j)*7) mod 256. Round key i is K0 ^ L'(tau(K1^K2^K3^CK_i)), with L'(b)=b^(b<<<13)^(b<<<23). The data round computes X0 ^ L(tau(X1^X2^X3^rk)), with L(b)=b^(b<<<2)^(b<<<10)^(b<<<18)^(b<<<24).
- R9: The last four data words X32..X35 appear on `dout` as X35 in bits 127:96 down to X32 in bits 31:0.
- R10: The byte substitution is S(x) = Aff(Inv(Aff(x))). Inv is inversion in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1, with Inv(0)=0. Aff(v) = M·v ^ 0xD3, where the rows of M (output bit 7 first) are D3 E9 F4 7A 3D 9E 4F A7. This gives S(00)=D6 and S(01)=90.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to encrypt; sampled only while idle |
| key_in | input | 128 | Master key, captured on the accepting edge |
| din | input | 128 | Plaintext block, captured on the accepting edge |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when `dout` carries a new result |
| dout | output | 128 | Ciphertext of the last completed block |

## Verification
Every internal fault in this block surfaces at `dout` when the block completes, 32 cycles after launch. A wrong round constant, S-box byte, linear rotation, whitening word or word order corrupts the whole ciphertext, so a full-width compare against an independent model catches it. Faults in the round counter show up as a `done` pulse that arrives early, arrives late, repeats or never comes. A relaunch while busy shows up as a result that is late or that belongs to the wrong input. To catch these, each completion is timed against its launch cycle, and the number of completions is compared with the number of launches.

// File: rtl/sm4_pkg.sv
`timescale 1ns/1ps
package sm4_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BLOCK_W = 4 * WORD_W;

  // key whitening words, first word in the top bits
  localparam logic [BLOCK_W-1:0] WHITEN_KEY =
    128'hA3B1BAC6_56AA3350_677D9197_B27022DC;

  // affine map rows, row 0 drives output bit 7
  localparam logic [63:0] AFF_ROWS = 64'hD3E9F47A_3D9E4FA7;
  localparam logic [7:0]  AFF_CONST = 8'hD3;
  // reduction of x^8 for x^8+x^7+x^6+x^5+x^4+x^2+1
  localparam logic [7:0]  GF_RED   = 8'hF5;
  localparam logic [7:0]  INV_EXP  = 8'd254;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ GF_RED) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // a^254 is the inverse for a != 0 and gives 0 for a == 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] base;
    res  = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (INV_EXP[i]) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    return res;
  endfunction

  function automatic logic [7:0] aff_map(input logic [7:0] v);
    logic [7:0] y;
    for (int r = 0; r < 8; r++) begin
      y[7-r] = ^(AFF_ROWS[63-8*r -: 8] & v);
    end
    return y ^ AFF_CONST;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    return aff_map(gf_inv(aff_map(x)));
  endfunction

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] w, input int unsigned n);
    return (w << n) | (w >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] lin_data(input logic [WORD_W-1:0] b);
    return b ^ rotl(b, 2) ^ rotl(b, 10) ^ rotl(b, 18) ^ rotl(b, 24);
  endfunction

  function automatic logic [WORD_W-1:0] lin_key(input logic [WORD_W-1:0] b);
    return b ^ rotl(b, 13) ^ rotl(b, 23);
  endfunction

  function automatic logic [WORD_W-1:0] round_const(input int unsigned idx);
    logic [WORD_W-1:0] w;
    for (int j = 0; j < 4; j++) begin
      int unsigned v;
      v = (4 * idx + j) * 7;
      w[WORD_W-1-8*j -: 8] = 8'(v);
    end
    return w;
  endfunction

  function automatic logic [BLOCK_W-1:0] word_reverse(input logic [BLOCK_W-1:0] s);
    return {s[31:0], s[63:32], s[95:64], s[127:96]};
  endfunction

endpackage

// File: rtl/sm4_tau.sv
`timescale 1ns/1ps
module sm4_tau #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0] word_in,
  output logic [8*LANES-1:0] word_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_out[8*g +: 8] = sm4_pkg::sub_byte(word_in[8*g +: 8]);
  end
endmodule

// File: rtl/sm4_key_round.sv
`timescale 1ns/1ps
module sm4_key_round #(
  parameter int unsigned CNT_W = 5
) (
  input  logic [127:0]     kst,
  input  logic [CNT_W-1:0] rnd,
  output logic [127:0]     kst_nxt,
  output logic [31:0]      rkey
);
  logic [31:0] ck_word;
  logic [31:0] mix_in;
  logic [31:0] sub_out;

  assign ck_word = sm4_pkg::round_const(int'(rnd));
  assign mix_in  = kst[95:64] ^ kst[63:32] ^ kst[31:0] ^ ck_word;

  sm4_tau #(.LANES(4)) u_tau (
    .word_in (mix_in),
    .word_out(sub_out)
  );

  assign rkey    = kst[127:96] ^ sm4_pkg::lin_key(sub_out);
  assign kst_nxt = {kst[95:0], rkey};
endmodule

// File: rtl/sm4_data_round.sv
`timescale 1ns/1ps
module sm4_data_round (
  input  logic [127:0] dst,
  input  logic [31:0]  rkey,
  output logic [127:0] dst_nxt
);
  logic [31:0] mix_in;
  logic [31:0] sub_out;
  logic [31:0] new_word;

  assign mix_in = dst[95:64] ^ dst[63:32] ^ dst[31:0] ^ rkey;

  sm4_tau #(.LANES(4)) u_tau (
    .word_in (mix_in),
    .word_out(sub_out)
  );

  assign new_word = dst[127:96] ^ sm4_pkg::lin_data(sub_out);
  assign dst_nxt  = {dst[95:0], new_word};
endmodule

// File: rtl/sm4_round_ctrl.sv
`timescale 1ns/1ps
module sm4_round_ctrl #(
  parameter int unsigned ROUNDS = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             load,
  output logic             step,
  output logic             last_round,
  output logic [CNT_W-1:0] rnd
);
  logic             busy_q;
  logic [CNT_W-1:0] rnd_q;

  assign load       = start && !busy_q;
  assign step       = busy_q;
  assign last_round = busy_q && (rnd_q == CNT_W'(ROUNDS - 1));
  assign busy       = busy_q;
  assign rnd        = rnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      rnd_q  <= '0;
    end else if (step) begin
      rnd_q <= rnd_q + 1'b1;
      if (last_round) busy_q <= 1'b0;
    end
  end

  AST_LAUNCH_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy_q && rnd_q == '0)); // R4

  AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && !last_round) |=> (busy_q && rnd_q == CNT_W'($past(rnd_q) + 1'b1))); // R5

  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
    last_round |=> !busy_q); // R3
endmodule

// File: rtl/sm4_lockstep_enc.sv
`timescale 1ns/1ps
module sm4_lockstep_enc #(
  parameter int unsigned ROUNDS = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [127:0] key_in,
  input  logic [127:0] din,
  output logic         busy,
  output logic         done,
  output logic [127:0] dout
);
  localparam int unsigned CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  logic             load;
  logic             step;
  logic             last_round;
  logic [CNT_W-1:0] rnd;

  logic [127:0] key_st;
  logic [127:0] data_st;
  logic [127:0] key_nxt;
  logic [127:0] data_nxt;
  logic [31:0]  rkey;

  sm4_round_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .load      (load),
    .step      (step),
    .last_round(last_round),
    .rnd       (rnd)
  );

  sm4_key_round #(.CNT_W(CNT_W)) u_key (
    .kst    (key_st),
    .rnd    (rnd),
    .kst_nxt(key_nxt),
    .rkey   (rkey)
  );

  sm4_data_round u_data (
    .dst    (data_st),
    .rkey   (rkey),
    .dst_nxt(data_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_st  <= '0;
      data_st <= '0;
    end else if (load) begin
      key_st  <= key_in ^ sm4_pkg::WHITEN_KEY;
      data_st <= din;
    end else if (step) begin
      key_st  <= key_nxt;
      data_st <= data_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      dout <= '0;
    end else begin
      done <= last_round;
      if (last_round) dout <= sm4_pkg::word_reverse(data_nxt);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    last_round |=> done); // R3

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R4

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dout)); // R6
endmodule

// File: tb/sm4_lockstep_enc_bench.sv
`timescale 1ns/1ps
module sm4_lockstep_enc_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] key_in = '0;
  logic [127:0] din = '0;
  logic         busy;
  logic         done;
  logic [127:0] dout;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int launches = 0;
  int completions = 0;
  logic [127:0] last_exp = '0;

  logic [127:0] exp_q[$];
  int           cyc_q[$];
  logic [7:0]   sb[256];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sm4_lockstep_enc u_sm4_lockstep_enc (
    .clk(clk), .rst(rst), .start(start), .key_in(key_in), .din(din),
    .busy(busy), .done(done), .dout(dout)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h1F5 << (k - 8));
    return p[7:0];
  endfunction

  // columns of the affine matrix, column c belongs to input bit 7-c
  function automatic logic [7:0] baff(input logic [7:0] v);
    logic [7:0] cols [8];
    logic [7:0] y;
    cols = '{8'hE5, 8'hF2, 8'h79, 8'hBC, 8'h5E, 8'h2F, 8'h97, 8'hCB};
    y = 8'hD3;
    for (int c = 0; c < 8; c++) if (v[7-c]) y = y ^ cols[c];
    return y;
  endfunction

  task automatic build_sbox();
    logic [7:0] inv [256];
    inv[0] = 8'h00;
    for (int a = 1; a < 256; a++) begin
      inv[a] = 8'h00;
      for (int b = 1; b < 256; b++)
        if (bmul(8'(a), 8'(b)) == 8'h01) inv[a] = 8'(b);
    end
    for (int x = 0; x < 256; x++) sb[x] = baff(inv[baff(8'(x))]);
  endtask

  function automatic logic [31:0] rol(input logic [31:0] b, input int n);
    return (b << n) | (b >> (32 - n));
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] key, input logic [127:0] pt);
    logic [31:0] k [4];
    logic [31:0] x [4];
    logic [127:0] kw;
    logic [31:0] ck, t, rk, nx;
    kw = key ^ 128'hA3B1BAC6_56AA3350_677D9197_B27022DC;   // R7
    for (int w = 0; w < 4; w++) begin
      k[w] = kw[127-32*w -: 32];
      x[w] = pt[127-32*w -: 32];
    end
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'(((4*i)+j)*7);   // R8
      t  = subw(k[1] ^ k[2] ^ k[3] ^ ck);
      rk = k[0] ^ t ^ rol(t, 13) ^ rol(t, 23);
      k[0] = k[1]; k[1] = k[2]; k[2] = k[3]; k[3] = rk;
      t  = subw(x[1] ^ x[2] ^ x[3] ^ rk);
      nx = x[0] ^ t ^ rol(t, 2) ^ rol(t, 10) ^ rol(t, 18) ^ rol(t, 24);
      x[0] = x[1]; x[1] = x[2]; x[2] = x[3]; x[3] = nx;
    end
    return {x[3], x[2], x[1], x[0]};   // R9
  endfunction

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      completions++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected done", dout, '0);
      end else begin
        logic [127:0] e;
        int lc;
        e  = exp_q.pop_front();
        lc = cyc_q.pop_front();
        last_exp = e;
        check(dout === e, "R2 R7 R8 R9 R10 ciphertext", dout, e);
        check((cyc - lc) == 33, "R3 latency", 128'(cyc - lc), 128'd33);
      end
    end
  end

  // driver: wait for idle, launch one block, push the expected result
  task automatic launch(input logic [127:0] k, input logic [127:0] p);
    @(negedge clk);
    while (busy) @(negedge clk);
    key_in = k;
    din    = p;
    start  = 1'b1;
    exp_q.push_back(ref_enc(k, p));
    cyc_q.push_back(cyc);
    launches++;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R4 busy after accept", 128'(busy), 128'd1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [127:0] STD_VEC = 128'h01234567_89abcdef_fedcba98_76543210;

  initial begin
    build_sbox();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy in reset", 128'(busy), '0);
    check(done === 1'b0, "R1 done in reset", 128'(done), '0);
    check(dout === '0, "R1 dout in reset", dout, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && dout === '0, "R1 idle after reset", dout, '0);

    // R2 known answer
    launch(STD_VEC, STD_VEC);
    drain();
    check(dout === 128'h681edf34_d206965e_86b3e94f_536e4246, "R2 known answer",
          dout, 128'h681edf34_d206965e_86b3e94f_536e4246);
    check(busy === 1'b0, "R4 busy low after done", 128'(busy), '0);

    // several distinct patterns, launched back to back (R3)
    launch('0, '0);
    launch({128{1'b1}}, {128{1'b1}});
    for (int i = 1; i <= 4; i++) begin
      logic [31:0] a, b;
      a = 32'h9E3779B9 * i;
      b = 32'h7F4A7C15 ^ (32'h01000193 * i);
      launch({a, b, ~a, a ^ b}, {b, a + b, a, ~b});
    end
    launch(STD_VEC, '0);
    drain();

    // R5 start while busy is ignored
    launch(128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0, 128'hdeadbeef_00112233_44556677_8899aabb);
    repeat (8) @(negedge clk);
    key_in = {128{1'b1}};
    din    = 128'h55555555_aaaaaaaa_55555555_aaaaaaaa;
    start  = 1'b1;
    repeat (4) @(negedge clk);
    start  = 1'b0;
    drain();
    check(dout === last_exp, "R5 result of first block kept", dout, last_exp);
    repeat (40) @(negedge clk);
    check(completions == launches, "R5 no extra result", 128'(completions), 128'(launches));

    // R6 output holds between completions
    check(dout === last_exp, "R6 dout held", dout, last_exp);
    check(done === 1'b0 && busy === 1'b0, "R6 quiet idle", 128'({busy, done}), '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule